// File: doc/BRIEF.md
# Output Completion Counter with Interrupt Coalescing

This block keeps a running tally of completed output work for one port and decides when the host should be interrupted. Each sent-event strobe adds either one, in packet mode, or the event's byte length, in byte mode, to a 32-bit count. Software never overwrites the count. It reports how much work it has consumed by writing that amount, and the block subtracts it.

An interrupt is raised when the count exceeds a programmable count level. It is also raised when work has been pending too long. A timer advances once every 2048 clock cycles while the count is nonzero, and the interrupt is raised when that timer exceeds a programmable time level. When the count drains to zero, the timer and the interrupt clear together.

A message-request pulse marks each new interrupt. A resend strobe asks for the message again if the interrupt is still pending. The delivery of that message is left to the surrounding logic.

Register select encoding on `reg_sel`:
- 0: count. A read returns the count. A write subtracts the written value.
- 1: count level, 32 bits.
- 2: configuration. Bit 31 is byte mode (1 = bytes, 0 = packets). Bit 30 is the counting enable. Bits 21:0 are the time level.
- 3: status, read only. Bit 31 is the interrupt. Bits 21:0 are the timer.

Top module: `pkt_out_coalescer`

## Requirements
- R1: After reset the count, timer, count level, time level, byte mode and enable are all zero, and `irq` and `msg_req` are low.
- R2: With the enable set and byte mode clear, each cycle with `sent` high adds exactly one to the count.
- R3: With the enable and byte mode (configuration bit 31) set, each cycle with `sent` high adds `sent_len` to the count.
- R4: With the enable (configuration bit 30) clear, `sent` has no effect on the count.
- R5: A write to register 0 subtracts the written value from the count. An event and a subtract in the same cycle apply as count + add - sub, clamped at zero and saturating at the all-ones value.
- R6: The timer increments once every 2048 cycles, and only while the count is nonzero. It is readable in status bits 21:0.
- R7: When the count becomes zero, the timer returns to zero and `irq` falls in that same cycle.
- R8: `irq` is high exactly when count > count level or timer > time level. Both comparisons are strict.
- R9: `msg_req` pulses high for one cycle, one cycle after `irq` rises.
- R10: A `resend` pulse while `irq` is high produces a `msg_req` pulse on the next cycle. A `resend` while `irq` is low produces none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sent | input | 1 | One output event completed this cycle |
| sent_len | input | 16 | Byte length of the event |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| resend | input | 1 | Request to re-issue the interrupt message |
| irq | output | 1 | Level interrupt |
| msg_req | output | 1 | One-cycle message request pulse |

## Verification
The hardest state to reach from the ports is a timer-driven interrupt. It needs a small nonzero count to sit below its level for several 2048-cycle periods, and then it needs a subtract that drains the count while the timer is above its level.

A directed phase programs a time level of 2 with an unreachable count level and idles for more than three prescale periods. It then subtracts the count away and checks that the timer and the interrupt clear in the same cycle.

A random phase with a fixed seed mixes events, mode changes, over-subtracts and resends. Every cycle it is compared against a cycle model computed in the bench.

// File: rtl/oc_pkg.sv
package oc_pkg;
    localparam int CNT_W    = 32;
    localparam int TMR_W    = 22;
    localparam int LEN_W    = 16;
    localparam int PRESCALE = 2048;

    typedef enum logic [1:0] {
        SEL_COUNT = 2'd0,
        SEL_CLVL  = 2'd1,
        SEL_CFG   = 2'd2,
        SEL_STAT  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             byte_mode;
        logic             enable;
        logic [TMR_W-1:0] tlvl;
        logic [CNT_W-1:0] clvl;
    } cfg_t;
endpackage

// File: rtl/oc_count_unit.sv
module oc_count_unit #(
    parameter int CNT_W = oc_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] add_val,
    input  logic             sub_en,
    input  logic [CNT_W-1:0] sub_val,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_next_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W:0] wide;
    logic [CNT_W:0] sub_w;

    always_comb begin
        st_d  = st_q;
        sub_w = sub_en ? {1'b0, sub_val} : '0;
        wide  = {1'b0, st_q.cnt} + {1'b0, add_val};
        if (wide >= sub_w) begin
            wide = wide - sub_w;
        end else begin
            wide = '0;
        end
        if (wide[CNT_W]) begin
            st_d.cnt = '1;
        end else begin
            st_d.cnt = wide[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o       = st_q.cnt;
    assign zero_next_o = (st_d.cnt == '0);

    AST_SUB_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_en && add_val == '0) |=> (cnt_o <= $past(cnt_o)));  // R5
    AST_ADD_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!sub_en) |=> (cnt_o >= $past(cnt_o)));  // R2
endmodule

// File: rtl/oc_tick_timer.sv
module oc_tick_timer #(
    parameter int TMR_W    = oc_pkg::TMR_W,
    parameter int PRESCALE = oc_pkg::PRESCALE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             clear,
    output logic [TMR_W-1:0] tmr_o
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

    typedef struct packed {
        logic [PW-1:0]    pre;
        logic [TMR_W-1:0] tmr;
    } st_t;

    st_t  st_d, st_q;
    logic tick;

    always_comb begin
        st_d = st_q;
        tick = busy && (st_q.pre == PRE_LAST);
        if (busy) begin
            st_d.pre = tick ? '0 : st_q.pre + 1'b1;
        end else begin
            st_d.pre = '0;
        end
        if (tick && (st_q.tmr != '1)) begin
            st_d.tmr = st_q.tmr + 1'b1;
        end
        if (clear) begin
            st_d.pre = '0;
            st_d.tmr = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tmr_o = st_q.tmr;

    AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (tmr_o == $past(tmr_o) || tmr_o == $past(tmr_o) + 1'b1 || tmr_o == '0));  // R6
    AST_TMR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy) |=> (tmr_o == $past(tmr_o) || tmr_o == '0));  // R6
endmodule

// File: rtl/oc_irq_gen.sv
module oc_irq_gen #(
    parameter int CNT_W = oc_pkg::CNT_W,
    parameter int TMR_W = oc_pkg::TMR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] clvl,
    input  logic [TMR_W-1:0] tmr,
    input  logic [TMR_W-1:0] tlvl,
    input  logic             resend,
    output logic             irq_o,
    output logic             msg_o
);
    typedef struct packed {
        logic prev;
        logic msg;
    } st_t;

    st_t  st_d, st_q;
    logic cond;

    always_comb begin
        cond      = (cnt > clvl) || (tmr > tlvl);
        st_d.prev = cond;
        st_d.msg  = cond && (!st_q.prev || resend);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = cond;
    assign msg_o = st_q.msg;

    AST_MSG_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        msg_o |-> $past(irq_o));  // R9
    AST_MSG_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |=> msg_o);  // R9
    AST_RESEND_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (resend && !irq_o) |=> !msg_o);  // R10
endmodule

// File: rtl/pkt_out_coalescer.sv
module pkt_out_coalescer #(
    parameter int CNT_W    = oc_pkg::CNT_W,
    parameter int TMR_W    = oc_pkg::TMR_W,
    parameter int LEN_W    = oc_pkg::LEN_W,
    parameter int PRESCALE = oc_pkg::PRESCALE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sent,
    input  logic [LEN_W-1:0] sent_len,
    input  logic             reg_wr,
    input  logic [1:0]       reg_sel,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    input  logic             resend,
    output logic             irq,
    output logic             msg_req
);
    import oc_pkg::*;

    localparam int BYTE_BIT = CNT_W - 1;
    localparam int EN_BIT   = CNT_W - 2;

    typedef struct packed {
        logic             byte_mode;
        logic             enable;
        logic [TMR_W-1:0] tlvl;
        logic [CNT_W-1:0] clvl;
    } cfg_st_t;

    cfg_st_t          cfg_d, cfg_q;
    logic [CNT_W-1:0] add_val;
    logic             sub_en;
    logic [CNT_W-1:0] cnt;
    logic             zero_next;
    logic [TMR_W-1:0] tmr;

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr) begin
            case (reg_sel_e'(reg_sel))
                SEL_CLVL: cfg_d.clvl = reg_wdata;
                SEL_CFG: begin
                    cfg_d.byte_mode = reg_wdata[BYTE_BIT];
                    cfg_d.enable    = reg_wdata[EN_BIT];
                    cfg_d.tlvl      = reg_wdata[TMR_W-1:0];
                end
                default: ;
            endcase
        end
        sub_en = reg_wr && (reg_sel_e'(reg_sel) == SEL_COUNT);
        if (!cfg_q.enable || !sent) begin
            add_val = '0;
        end else if (cfg_q.byte_mode) begin
            add_val = CNT_W'(sent_len);
        end else begin
            add_val = CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    oc_count_unit #(.CNT_W(CNT_W)) i_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .add_val     (add_val),
        .sub_en      (sub_en),
        .sub_val     (reg_wdata),
        .cnt_o       (cnt),
        .zero_next_o (zero_next)
    );

    oc_tick_timer #(.TMR_W(TMR_W), .PRESCALE(PRESCALE)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .busy  (cnt != '0),
        .clear (zero_next),
        .tmr_o (tmr)
    );

    oc_irq_gen #(.CNT_W(CNT_W), .TMR_W(TMR_W)) i_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt    (cnt),
        .clvl   (cfg_q.clvl),
        .tmr    (tmr),
        .tlvl   (cfg_q.tlvl),
        .resend (resend),
        .irq_o  (irq),
        .msg_o  (msg_req)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_sel_e'(reg_sel))
            SEL_COUNT: reg_rdata = cnt;
            SEL_CLVL:  reg_rdata = cfg_q.clvl;
            SEL_CFG: begin
                reg_rdata[TMR_W-1:0] = cfg_q.tlvl;
                reg_rdata[BYTE_BIT]  = cfg_q.byte_mode;
                reg_rdata[EN_BIT]    = cfg_q.enable;
            end
            default: begin
                reg_rdata[TMR_W-1:0] = tmr;
                reg_rdata[BYTE_BIT]  = irq;
            end
        endcase
    end

    AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> (tmr == '0 && !irq));  // R7
    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.enable && !sub_en) |=> (cnt == $past(cnt)));  // R4
endmodule

// File: tb/test_pkt_out_coalescer.sv
module test_pkt_out_coalescer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        sent;
    logic [15:0] sent_len;
    logic        reg_wr;
    logic [1:0]  reg_sel;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        resend;
    logic        irq;
    logic        msg_req;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    pkt_out_coalescer i_pkt_out_coalescer (
        .clk(clk), .rst_n(rst_n), .sent(sent), .sent_len(sent_len),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .resend(resend), .irq(irq), .msg_req(msg_req)
    );

    // reference state
    logic [31:0] m_cnt, m_clvl;
    logic [21:0] m_tmr, m_tlvl;
    int          m_pre;
    bit          m_prev, m_msg, m_byte, m_en;

    function automatic bit m_irq();
        return (m_cnt > m_clvl) || (m_tmr > m_tlvl);
    endfunction

    function automatic logic [31:0] m_read(input logic [1:0] sel);
        logic [31:0] r;
        r = '0;
        case (sel)
            2'd0: r = m_cnt;
            2'd1: r = m_clvl;
            2'd2: begin r[21:0] = m_tlvl; r[31] = m_byte; r[30] = m_en; end
            default: begin r[21:0] = m_tmr; r[31] = m_irq(); end
        endcase
        return r;
    endfunction

    task automatic m_reset();
        m_cnt = 0; m_clvl = 0; m_tmr = 0; m_tlvl = 0; m_pre = 0;
        m_prev = 0; m_msg = 0; m_byte = 0; m_en = 0;
    endtask

    task automatic m_update();
        logic [32:0] w;
        logic [32:0] a;
        logic [32:0] s;
        bit          cur;
        bit          busy;
        cur  = m_irq();
        busy = (m_cnt != 0);
        a = (m_en && sent) ? (m_byte ? 33'(sent_len) : 33'd1) : 33'd0;
        s = (reg_wr && reg_sel == 2'd0) ? 33'(reg_wdata) : 33'd0;
        w = 33'(m_cnt) + a;
        w = (w >= s) ? w - s : 33'd0;
        m_msg  = cur && (!m_prev || resend);
        m_prev = cur;
        if (busy) begin
            if (m_pre == 2047) begin
                m_pre = 0;
                if (m_tmr != 22'h3FFFFF) m_tmr = m_tmr + 1;
            end else begin
                m_pre = m_pre + 1;
            end
        end else begin
            m_pre = 0;
        end
        m_cnt = w[32] ? 32'hFFFF_FFFF : w[31:0];
        if (m_cnt == 0) begin
            m_tmr = 0;
            m_pre = 0;
        end
        if (reg_wr && reg_sel == 2'd1) m_clvl = reg_wdata;
        if (reg_wr && reg_sel == 2'd2) begin
            m_byte = reg_wdata[31]; m_en = reg_wdata[30]; m_tlvl = reg_wdata[21:0];
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        sent = 0; sent_len = 0; reg_wr = 0; reg_sel = 0; reg_wdata = 0; resend = 0;
    endtask

    // one clock: inputs already driven; update model at the edge, compare at negedge
    task automatic step(input string tag);
        @(posedge clk);
        m_update();
        @(negedge clk);
        chk({tag, " irq"}, 32'(irq), 32'(m_irq()));
        chk({tag, " msg_req"}, 32'(msg_req), 32'(m_msg));
        chk({tag, " rdata"}, reg_rdata, m_read(reg_sel));
        idle();
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d, input string tag);
        reg_wr = 1; reg_sel = sel; reg_wdata = d;
        step(tag);
    endtask

    task automatic rd(input logic [1:0] sel, input logic [31:0] exp, input string tag);
        reg_sel = sel;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic ev(input logic [15:0] len, input string tag);
        sent = 1; sent_len = len;
        step(tag);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        idle();
        rst_n = 0;
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 irq", 32'(irq), 0);
        chk("R1 msg_req", 32'(msg_req), 0);
        rd(2'd0, 0, "R1 count");
        rd(2'd2, 0, "R1 config");
        rd(2'd3, 0, "R1 status");
        idle();

        // R2 packet counting, R8 strict level, R9 pulse
        wr(2'd1, 32'd3, "R8 clvl");
        wr(2'd2, 32'h4000_0000 | 32'h3F_FFFF, "R2 cfg");
        for (int i = 0; i < 3; i++) ev(16'd77, "R2 event");
        rd(2'd0, 32'd3, "R2 count after 3");
        chk("R8 equal not above", 32'(irq), 0);
        idle();
        ev(16'd77, "R2 event");
        chk("R8 irq above level", 32'(irq), 1);
        chk("R9 msg not same cycle", 32'(msg_req), 0);
        step("R9 wait");
        chk("R9 msg pulse", 32'(msg_req), 1);
        step("R9 wait");
        chk("R9 msg one cycle", 32'(msg_req), 0);

        // R10 resend while pending
        resend = 1;
        step("R10 resend high");
        chk("R10 resend pulse", 32'(msg_req), 1);

        // R4 disabled
        wr(2'd2, 32'h3F_FFFF, "R4 cfg");
        for (int i = 0; i < 5; i++) ev(16'd9, "R4 event");
        rd(2'd0, 32'd4, "R4 count held");
        idle();

        // R3 byte mode
        wr(2'd2, 32'hC000_0000 | 32'h3F_FFFF, "R3 cfg");
        ev(16'd100, "R3 event");
        rd(2'd0, 32'd104, "R3 count bytes");
        idle();

        // R5 simultaneous add and subtract
        sent = 1; sent_len = 16'd10; reg_wr = 1; reg_sel = 2'd0; reg_wdata = 32'd50;
        step("R5 add sub");
        rd(2'd0, 32'd64, "R5 combined");
        idle();
        // R5 over-subtract clamps, R7 irq clears
        wr(2'd0, 32'd1000, "R5 clamp");
        rd(2'd0, 32'd0, "R5 clamp zero");
        chk("R7 irq clear", 32'(irq), 0);
        idle();
        // R10 resend with no pending interrupt
        resend = 1;
        step("R10 resend low");
        chk("R10 no msg", 32'(msg_req), 0);

        // R6 timer: count 1 below an unreachable level, time level 2
        wr(2'd1, 32'hFFFF_FFFF, "R6 clvl");
        wr(2'd2, 32'h8000_0000 | 32'h4000_0000 | 32'd2, "R6 cfg");
        ev(16'd1, "R6 event");
        for (int i = 0; i < 2048 * 3 + 20; i++) begin
            reg_sel = 2'd3;
            step("R6 R8 timer");
        end
        rd(2'd3, 32'h8000_0003, "R6 timer value and irq");
        idle();
        wr(2'd0, 32'd1, "R7 drain");
        rd(2'd3, 32'd0, "R7 timer cleared");
        chk("R7 irq low", 32'(irq), 0);
        idle();

        // random phase
        wr(2'd1, 32'd20, "rand clvl");
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            sent     = ($urandom_range(0, 2) != 0);
            sent_len = 16'($urandom_range(0, 12));
            resend   = ($urandom_range(0, 9) == 0);
            reg_sel  = 2'($urandom_range(0, 3));
            if (r < 8) begin
                reg_wr = 1; reg_sel = 2'd0; reg_wdata = $urandom_range(0, 40);
            end else if (r < 10) begin
                reg_wr = 1; reg_sel = 2'd2;
                reg_wdata = {1'($urandom_range(0, 1)), 1'($urandom_range(0, 5) != 0),
                             8'd0, 22'($urandom_range(0, 3))};
            end else if (r < 11) begin
                reg_wr = 1; reg_sel = 2'd1; reg_wdata = $urandom_range(0, 40);
            end
            step("R2 R3 R4 R5 R8 R9 R10 random");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule